// File: doc/BRIEF.md
# Direct-Mapped Four-Word-Line Cache

This block is a direct-mapped cache placed between a processor's word-wide load/store port and a simple lower-level memory. It has 4096 lines, and each line holds four 32-bit words. Because a miss brings in a whole line, later accesses to nearby words hit without touching memory.

The processor presents an address with a read or write strobe and holds it until `cpu_stall` is low at a clock edge. On a miss, the cache fetches the whole line from memory one word at a time, from the first word to the last. It marks the line present only when the last word has arrived. The stalled access then completes as a hit.

Writes are write-through. A write to a present line updates the cached word and sends one memory write. The processor stays stalled until memory accepts that write. A write to an absent line first fills the line and then performs the write.

The memory side uses one handshake for both reads and writes. The cache raises `mem_req` and holds `mem_addr`, `mem_we` and `mem_wdata` steady. Memory answers with a single-cycle `mem_valid` pulse, which carries `mem_rdata` for a read. Memory may take any number of cycles to answer.

Top module: `cache_dm`

## Requirements
- R1: The address is split into tag bits 31:16, line index bits 15:4, word select bits 3:2 and byte bits 1:0. Once a line is filled, a read to any word of that line with the same tag completes with `cpu_stall` low in its first cycle and causes no memory read.
- R2: Address bits 3:2 select which word of the line appears on `cpu_rdata`. Address bits 1:0 have no effect on which word is returned.
- R3: A read miss raises `cpu_stall` and fetches the line with four memory reads. Their word addresses are line base + 0, +4, +8 and +12, in that order. The read then returns the word stored in memory.
- R4: An access whose index matches a filled line but whose tag differs is a miss. Its fill replaces that line, so the old tag misses again afterwards.
- R5: A write to a present line updates the cached word and issues exactly one memory write with `mem_we` = 1 to the word address. `cpu_stall` stays high until memory answers that write.
- R6: A write miss first fills the whole line with four memory reads and then performs the write as in R5. A later read of any word of that line hits and returns the merged data.
- R7: Synchronous active-high reset makes every line absent. The first access after reset to any address misses and fills.
- R8: While `mem_req` is high and `mem_valid` is low, `mem_req`, `mem_we` and `mem_addr` stay unchanged. The block works for any response latency, including zero wait cycles.
- R9: With neither strobe high, `cpu_stall` and `mem_req` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_rd | input | 1 | Read strobe, held until not stalled |
| cpu_wr | input | 1 | Write strobe, held until not stalled; has priority over the read strobe |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid when a read is not stalled |
| cpu_stall | output | 1 | The access is not yet complete |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_valid | input | 1 | One-cycle response from memory: the request is done |
| mem_rdata | input | 32 | Memory read data, valid with `mem_valid` |

## Verification
The properties assume that the processor keeps its address, strobes and write data unchanged while `cpu_stall` is high. They also assume that memory pulses `mem_valid` only while `mem_req` is high and never in two consecutive cycles. The bench drives the processor side through a task that holds every input until the stall clears. Its memory model answers only a pending request after a programmable wait and always leaves a gap cycle after each response. The wait is varied between zero and five cycles, so the handshake is exercised at its fastest and with long holds.

// File: rtl/cache_pkg.sv
package cache_pkg;
    localparam int ADDR_W  = 32;
    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 2;
    localparam int SEL_W   = 2;
    localparam int INDEX_W = 12;
    localparam int TAG_W   = ADDR_W - INDEX_W - SEL_W - BYTE_W;

    typedef struct packed {
        logic [TAG_W-1:0]   tag;
        logic [INDEX_W-1:0] index;
        logic [SEL_W-1:0]   sel;
        logic [BYTE_W-1:0]  byte_sel;
    } cpu_addr_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_WRITE
    } ctl_state_t;

    function automatic logic [ADDR_W-1:0] word_addr(input cpu_addr_t a, input logic [SEL_W-1:0] sel);
        return {a.tag, a.index, sel, {BYTE_W{1'b0}}};
    endfunction
endpackage

// File: rtl/cache_tags.sv
module cache_tags #(
    parameter int INDEX_W = 12,
    parameter int TAG_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INDEX_W-1:0] rd_index,
    output logic               rd_valid,
    output logic [TAG_W-1:0]   rd_tag,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_index,
    input  logic [TAG_W-1:0]   wr_tag
);
    localparam int LINES = 1 << INDEX_W;

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_index] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_index] <= wr_tag;
        end
    end

    assign rd_valid = valid_q[rd_index];
    assign rd_tag   = tag_q[rd_index];
endmodule

// File: rtl/cache_lines.sv
module cache_lines #(
    parameter int INDEX_W = 12,
    parameter int SEL_W   = 2,
    parameter int WORD_W  = 32
) (
    input  logic               clk,
    input  logic [INDEX_W-1:0] rd_index,
    input  logic [SEL_W-1:0]   rd_sel,
    output logic [WORD_W-1:0]  rd_word,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_index,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [WORD_W-1:0]  wr_word
);
    localparam int LINES  = 1 << INDEX_W;
    localparam int WORDS  = 1 << SEL_W;
    localparam int LINE_W = WORDS * WORD_W;

    logic [LINE_W-1:0] line_q [LINES];
    logic [LINE_W-1:0] line_rd;
    logic [WORD_W-1:0] slot [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_q[wr_index][wr_sel*WORD_W +: WORD_W] <= wr_word;
        end
    end

    assign line_rd = line_q[rd_index];

    for (genvar w = 0; w < WORDS; w++) begin : g_slot
        assign slot[w] = line_rd[w*WORD_W +: WORD_W];
    end

    assign rd_word = slot[rd_sel];
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_rd,
    input  logic             cpu_wr,
    input  logic             hit,
    input  logic             mem_valid,
    output ctl_state_t       state,
    output logic [SEL_W-1:0] fill_sel,
    output logic             cpu_stall,
    output logic             mem_req,
    output logic             mem_we,
    output logic             line_install,
    output logic             word_we
);
    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'((1 << SEL_W) - 1);

    ctl_state_t       state_q, state_d;
    logic [SEL_W-1:0] cnt_q, cnt_d;
    logic             access;

    assign access = cpu_rd | cpu_wr;

    always_comb begin
        state_d      = state_q;
        cnt_d        = cnt_q;
        cpu_stall    = 1'b0;
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        line_install = 1'b0;
        word_we      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (access && !hit) begin
                    cpu_stall = 1'b1;
                    cnt_d     = '0;
                    state_d   = ST_FILL;
                end else if (cpu_wr) begin
                    cpu_stall = 1'b1;
                    state_d   = ST_WRITE;
                end
            end
            ST_FILL: begin
                cpu_stall = 1'b1;
                mem_req   = 1'b1;
                if (mem_valid) begin
                    word_we = 1'b1;
                    cnt_d   = cnt_q + 1'b1;
                    if (cnt_q == LAST_SEL) begin
                        line_install = 1'b1;
                        state_d      = ST_IDLE;
                    end
                end
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                cpu_stall = !mem_valid;
                if (mem_valid) begin
                    word_we = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state    = state_q;
    assign fill_sel = cnt_q;
endmodule

// File: rtl/cache_dm.sv
module cache_dm
    import cache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_valid,
    input  logic [WORD_W-1:0] mem_rdata
);
    cpu_addr_t         a;
    ctl_state_t        state;
    logic              stored_valid;
    logic [TAG_W-1:0]  stored_tag;
    logic              hit;
    logic [SEL_W-1:0]  fill_sel;
    logic              line_install;
    logic              word_we;
    logic              filling;
    logic [SEL_W-1:0]  dwr_sel;
    logic [WORD_W-1:0] dwr_word;
    logic [BYTE_W-1:0] unused_byte_sel;

    assign a               = cpu_addr_t'(cpu_addr);
    assign unused_byte_sel = a.byte_sel;

    cache_tags #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .rd_index (a.index),
        .rd_valid (stored_valid),
        .rd_tag   (stored_tag),
        .wr_en    (line_install),
        .wr_index (a.index),
        .wr_tag   (a.tag)
    );

    assign hit = stored_valid && (stored_tag == a.tag);

    cache_ctrl #(.SEL_W(SEL_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cpu_rd       (cpu_rd),
        .cpu_wr       (cpu_wr),
        .hit          (hit),
        .mem_valid    (mem_valid),
        .state        (state),
        .fill_sel     (fill_sel),
        .cpu_stall    (cpu_stall),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .line_install (line_install),
        .word_we      (word_we)
    );

    assign filling  = (state == ST_FILL);
    assign dwr_sel  = filling ? fill_sel : a.sel;
    assign dwr_word = filling ? mem_rdata : cpu_wdata;

    cache_lines #(.INDEX_W(INDEX_W), .SEL_W(SEL_W), .WORD_W(WORD_W)) u_lines (
        .clk      (clk),
        .rd_index (a.index),
        .rd_sel   (a.sel),
        .rd_word  (cpu_rdata),
        .wr_en    (word_we),
        .wr_index (a.index),
        .wr_sel   (dwr_sel),
        .wr_word  (dwr_word)
    );

    assign mem_addr  = word_addr(a, filling ? fill_sel : a.sel);
    assign mem_wdata = cpu_wdata;
endmodule

// File: rtl/cache_dm_chk.sv
module cache_dm_chk (
    input logic        clk,
    input logic        rst,
    input logic        cpu_rd,
    input logic        cpu_wr,
    input logic        cpu_stall,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic        mem_valid,
    input logic        hit
);
    // R1: a read may only complete on a hit
    assert_read_done_hits_R1: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && !cpu_wr && !cpu_stall) |-> hit);

    // R3: a miss stalls the processor
    assert_miss_stalls_R3: assert property (@(posedge clk) disable iff (rst)
        ((cpu_rd || cpu_wr) && !hit) |-> cpu_stall);

    // R3: the fill starts at the first word of the line
    assert_fill_starts_at_zero_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_req) && !mem_we) |-> (mem_addr[3:2] == 2'd0));

    // R3: the fill walks the words of the line in ascending order
    assert_fill_ascends_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_valid && (mem_addr[3:2] != 2'd3)) |=>
        (mem_req && !mem_we && (mem_addr[3:2] == $past(mem_addr[3:2]) + 2'd1)
         && (mem_addr[31:4] == $past(mem_addr[31:4]))));

    // R5: a write completes only together with the memory's answer to a write
    assert_write_through_R5: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !cpu_stall) |-> (mem_req && mem_we && mem_valid));

    // R7: nothing hits right after reset
    assert_empty_after_reset_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !hit);

    // R8: a pending request holds its command until answered
    assert_req_held_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

    // R9: with no strobe, the block is quiet toward the processor
    assert_idle_no_stall_R9: assert property (@(posedge clk) disable iff (rst)
        !(cpu_rd || cpu_wr) |-> !cpu_stall);
endmodule

bind cache_dm cache_dm_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_stall (cpu_stall),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_valid (mem_valid),
    .hit       (hit)
);

// File: tb/test_cache_dm.sv
`timescale 1ns/1ps
module test_cache_dm;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_stall;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int lat = 2;
    int wcnt = 0;
    int rd_words = 0;
    int wr_count = 0;
    int cycles = 0;
    logic [31:0] rd_log [8];

    logic [31:0] mem_model [logic [29:0]];
    logic [31:0] shadow [logic [29:0]];

    always #4 clk = ~clk;

    cache_dm i_cache_dm (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] dflt(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'hC0DE_0000;
    endfunction

    function automatic logic [31:0] expect_word(input logic [31:0] a);
        if (shadow.exists(a[31:2])) return shadow[a[31:2]];
        return dflt(a);
    endfunction

    // memory model: answers a pending request after lat wait cycles
    always @(negedge clk) begin
        if (mem_valid) begin
            mem_valid <= 1'b0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                wcnt = 0;
                mem_valid <= 1'b1;
                if (mem_we) begin
                    mem_model[mem_addr[31:2]] = mem_wdata;
                    wr_count++;
                end else begin
                    mem_rdata <= mem_model.exists(mem_addr[31:2]) ? mem_model[mem_addr[31:2]] : dflt(mem_addr);
                    rd_log[rd_words % 8] = mem_addr;
                    rd_words++;
                end
            end else begin
                wcnt++;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_access(input logic wr, input logic [31:0] a, input logic [31:0] wd,
                             output logic [31:0] rd, output int stalled);
        @(negedge clk);
        cpu_addr = a; cpu_rd = !wr; cpu_wr = wr; cpu_wdata = wd;
        stalled = 0;
        #1;
        while (cpu_stall) begin
            @(negedge clk);
            #1;
            stalled++;
        end
        rd = cpu_rdata;
        @(posedge clk);
        #1;
        cpu_rd = 1'b0; cpu_wr = 1'b0;
    endtask

    // full test: access, then check data, fill count and write count
    task automatic run_one(input logic wr, input logic [31:0] a, input logic [31:0] wd,
                           input int fills, input string req);
        logic [31:0] rd;
        int st;
        int r0 = rd_words;
        int w0 = wr_count;
        do_access(wr, a, wd, rd, st);
        if (wr) begin
            shadow[a[31:2]] = wd;
            check(wr_count - w0 == 1, {req, " one memory write"}, 32'(wr_count - w0), 32'd1);
            check(mem_model.exists(a[31:2]) && mem_model[a[31:2]] == wd, {req, " memory word written"},
                  mem_model.exists(a[31:2]) ? mem_model[a[31:2]] : 32'hx, wd);
        end else begin
            check(rd == expect_word(a), {req, " read data"}, rd, expect_word(a));
            check(wr_count == w0, {req, " no memory write on read"}, 32'(wr_count - w0), 32'd0);
            if (fills == 0)
                check(st == 0, {req, " hit completes without stall"}, 32'(st), 32'd0);
        end
        check(rd_words - r0 == 4 * fills, {req, " memory read words"}, 32'(rd_words - r0), 32'(4 * fills));
    endtask

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [1:0]  fills;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 32'h0000_0010, 32'h0, 2'd1},   // R3 cold read miss
        '{1'b0, 32'h0000_0014, 32'h0, 2'd0},   // R1 same line hit
        '{1'b0, 32'h0000_001C, 32'h0, 2'd0},   // R2 last word
        '{1'b1, 32'h0000_0018, 32'hDEAD_BEEF, 2'd0}, // R5 write hit
        '{1'b0, 32'h0000_0018, 32'h0, 2'd0},   // R5 read back merged
        '{1'b0, 32'h0001_0010, 32'h0, 2'd1},   // R4 conflicting tag
        '{1'b0, 32'h0000_0010, 32'h0, 2'd1},   // R4 evicted tag misses
        '{1'b1, 32'h0002_0024, 32'h1234_5678, 2'd1}, // R6 write miss allocates
        '{1'b0, 32'h0002_0020, 32'h0, 2'd0},   // R6 rest of allocated line
        '{1'b0, 32'h0002_0024, 32'h0, 2'd0},   // R6 merged word
        '{1'b0, 32'h0000_0018, 32'h0, 2'd0},   // R5 written-through value refetched
        '{1'b0, 32'hFFFF_FFF0, 32'h0, 2'd1},   // R1 top index, max tag
        '{1'b0, 32'hFFFF_FFFC, 32'h0, 2'd0}    // R2 top word select
    };

    initial begin
        logic [31:0] rd;
        int st;
        int r0;
        repeat (3) @(posedge clk);
        #1;
        // R9 / R7: quiet during and after reset
        check(cpu_stall == 1'b0, "R9 no stall in reset", {31'b0, cpu_stall}, 32'd0);
        check(mem_req == 1'b0, "R9 no request in reset", {31'b0, mem_req}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(cpu_stall == 1'b0 && mem_req == 1'b0, "R9 idle after reset",
              {30'b0, cpu_stall, mem_req}, 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            run_one(VEC[i].wr, VEC[i].addr, VEC[i].wdata, int'(VEC[i].fills), $sformatf("vec%0d", i));
            if (i == 0) begin
                for (int k = 0; k < 4; k++)
                    check(rd_log[k] == 32'h10 + 32'(4 * k), "R3 fill order", rd_log[k], 32'h10 + 32'(4 * k));
            end
        end

        // R2: byte bits have no effect
        run_one(1'b0, 32'h0000_0013, 32'h0, 0, "R2 byte bits ignored");
        check(expect_word(32'h13) == expect_word(32'h10), "R2 same word", expect_word(32'h13), expect_word(32'h10));

        // R8: zero-wait memory
        lat = 0;
        run_one(1'b0, 32'h0003_0048, 32'h0, 1, "R8 zero latency fill");
        run_one(1'b1, 32'h0003_004C, 32'hA5A5_0F0F, 0, "R8 zero latency write");
        // R8 / R6: long-wait memory with a write miss
        lat = 5;
        run_one(1'b1, 32'h0004_0054, 32'h0BAD_F00D, 1, "R6 slow write miss");
        run_one(1'b0, 32'h0004_0054, 32'h0, 0, "R6 slow read back");
        run_one(1'b0, 32'h0004_0058, 32'h0, 0, "R6 neighbour word");
        lat = 1;

        // R9: idle cycles produce no memory traffic
        r0 = rd_words;
        repeat (6) @(negedge clk);
        check(rd_words == r0 && mem_req == 1'b0, "R9 idle no traffic", 32'(rd_words - r0), 32'd0);

        // R7: reset forgets every line
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        run_one(1'b0, 32'h0004_0054, 32'h0, 1, "R7 refill after reset");
        r0 = rd_words;
        do_access(1'b0, 32'h0000_0010, 32'h0, rd, st);
        check(rd_words - r0 == 4, "R7 second line refilled", 32'(rd_words - r0), 32'd4);
        check(rd == expect_word(32'h10), "R7 data after refill", rd, expect_word(32'h10));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule